// File: doc/BRIEF.md
# Accumulator with Bit-Slice Adder and Logic Unit

This block holds a 16-bit accumulator together with a one-bit extend register that acts as the accumulator's carry and rotate companion. A column of identical one-bit slices sits in front of the accumulator. Each slice can add with a ripple carry, AND, pass the data operand, pass an input byte bit, invert, or take a neighbour bit for rotation. The slices see the accumulator itself, a 16-bit data operand and an 8-bit input byte.

A surrounding controller drives decoded, single-cycle enables. There are seven datapath operations that write the accumulator through the slices. There are also separate clear and increment strobes, and clear and complement strobes for the extend bit. The block reports the accumulator, the extend bit, the sign bit and a zero flag, which the controller uses for its skip decisions.

Top module: `accum_core`

## Requirements
- R1: While rst_n is low and at the first clock after it, acc_q is 0x0000 and ext_q is 0.
- R2: acc_clr sets acc_q to 0x0000 on the next edge and overrides every other accumulator enable. It suppresses the extend writes of op_add, op_shr and op_shl.
- R3: acc_inc without acc_clr sets acc_q to acc_q+1 modulo 2^16. It leaves ext_q alone and overrides the seven datapath enables.
- R4: op_add sets {ext_q, acc_q} to the 17-bit sum acc_q + dr_in, so the carry out of bit 15 lands in ext_q.
- R5: op_and sets acc_q to acc_q & dr_in. op_lddr sets acc_q to dr_in. Neither changes ext_q.
- R6: op_inp loads inp_in into acc_q[7:0] and keeps acc_q[15:8] and ext_q unchanged.
- R7: op_cma sets acc_q to ~acc_q and leaves ext_q unchanged.
- R8: op_shr rotates {acc_q, ext_q} right: acc_q[15] takes the old ext_q, bit i takes the old bit i+1, and ext_q takes the old acc_q[0].
- R9: op_shl rotates left: acc_q[0] takes the old ext_q, bit i takes the old bit i-1, and ext_q takes the old acc_q[15].
- R10: e_clr sets ext_q to 0. Otherwise e_cmp inverts ext_q. Both take priority over datapath extend writes, and neither changes acc_q.
- R11: With no enable asserted, acc_q and ext_q hold.
- R12: acc_neg equals acc_q[15]. acc_zero is 1 exactly when acc_q is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_and | input | 1 | AND data operand into accumulator |
| op_add | input | 1 | Add data operand, carry to extend bit |
| op_lddr | input | 1 | Load data operand |
| op_inp | input | 1 | Load input byte into low bits |
| op_cma | input | 1 | Invert accumulator |
| op_shr | input | 1 | Rotate right through extend bit |
| op_shl | input | 1 | Rotate left through extend bit |
| acc_clr | input | 1 | Clear accumulator |
| acc_inc | input | 1 | Increment accumulator |
| e_clr | input | 1 | Clear extend bit |
| e_cmp | input | 1 | Complement extend bit |
| dr_in | input | 16 | Data operand |
| inp_in | input | 8 | Input byte |
| acc_q | output | 16 | Accumulator value |
| ext_q | output | 1 | Extend bit |
| acc_neg | output | 1 | Accumulator sign bit |
| acc_zero | output | 1 | Accumulator is zero |

## Verification
All of the block's state is visible at its ports, so a wrong accumulator or extend value shows on acc_q or ext_q at the very next sample after the edge that wrote it. A broken carry link between slices shows only for operands whose carry reaches that slice. For that reason the stimulus includes full-length carries such as 0xFFFF+1. A wrong neighbour wiring in a slice shows on the first rotate. A wrong priority shows only when enables are combined, so clear, increment and datapath enables are also driven together.

// File: rtl/accum_pkg.sv
package accum_pkg;
  typedef struct packed {
    logic and_op;
    logic add_op;
    logic lddr_op;
    logic inp_op;
    logic cma_op;
    logic shr_op;
    logic shl_op;
  } accum_ops_t;

  function automatic logic ops_any(input accum_ops_t o);
    return o.and_op | o.add_op | o.lddr_op | o.inp_op |
           o.cma_op | o.shr_op | o.shl_op;
  endfunction
endpackage

// File: rtl/accum_slice.sv
module accum_slice
  import accum_pkg::*;
(
  input  accum_ops_t ops,
  input  logic       a_bit,
  input  logic       d_bit,
  input  logic       in_bit,
  input  logic       up_bit,
  input  logic       dn_bit,
  input  logic       cin,
  output logic       y,
  output logic       cout
);
  logic sum;

  always_comb begin
    sum  = a_bit ^ d_bit ^ cin;
    cout = (a_bit & d_bit) | (cin & (a_bit ^ d_bit));
    y    = (ops.and_op  & a_bit & d_bit) |
           (ops.add_op  & sum)           |
           (ops.lddr_op & d_bit)         |
           (ops.inp_op  & in_bit)        |
           (ops.cma_op  & ~a_bit)        |
           (ops.shr_op  & up_bit)        |
           (ops.shl_op  & dn_bit);
  end
endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_pkg::*;
#(
  parameter int W   = 16,
  parameter int INW = 8
) (
  input  accum_ops_t   ops,
  input  logic [W-1:0] acc,
  input  logic         ext,
  input  logic [W-1:0] dr,
  input  logic [INW-1:0] inp,
  output logic [W-1:0] y,
  output logic         ext_next
);
  localparam int TOP = W - 1;

  logic [W:0]   carry;
  logic [W-1:0] in_bits;
  logic [W-1:0] up_bits;
  logic [W-1:0] dn_bits;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_slice
    if (i < INW) begin : g_in
      assign in_bits[i] = inp[i];
    end else begin : g_keep
      assign in_bits[i] = acc[i];
    end
    if (i == TOP) begin : g_up_e
      assign up_bits[i] = ext;
    end else begin : g_up_n
      assign up_bits[i] = acc[i+1];
    end
    if (i == 0) begin : g_dn_e
      assign dn_bits[i] = ext;
    end else begin : g_dn_n
      assign dn_bits[i] = acc[i-1];
    end
    accum_slice u_slice (
      .ops    (ops),
      .a_bit  (acc[i]),
      .d_bit  (dr[i]),
      .in_bit (in_bits[i]),
      .up_bit (up_bits[i]),
      .dn_bit (dn_bits[i]),
      .cin    (carry[i]),
      .y      (y[i]),
      .cout   (carry[i+1])
    );
  end

  always_comb begin
    ext_next = ext;
    if (ops.add_op)      ext_next = carry[W];
    else if (ops.shr_op) ext_next = acc[0];
    else if (ops.shl_op) ext_next = acc[TOP];
  end
endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int W   = 16,
  parameter int INW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_and,
  input  logic           op_add,
  input  logic           op_lddr,
  input  logic           op_inp,
  input  logic           op_cma,
  input  logic           op_shr,
  input  logic           op_shl,
  input  logic           acc_clr,
  input  logic           acc_inc,
  input  logic           e_clr,
  input  logic           e_cmp,
  input  logic [W-1:0]   dr_in,
  input  logic [INW-1:0] inp_in,
  output logic [W-1:0]   acc_q,
  output logic           ext_q,
  output logic           acc_neg,
  output logic           acc_zero
);
  accum_ops_t   ops;
  logic [W-1:0] alu_y;
  logic         alu_e;
  logic         ld_en;
  logic [W-1:0] acc_d;
  logic         ext_d;
  logic         acc_en;
  logic         ext_en;

  assign ops = '{and_op: op_and, add_op: op_add, lddr_op: op_lddr,
                 inp_op: op_inp, cma_op: op_cma, shr_op: op_shr,
                 shl_op: op_shl};

  accum_alu #(.W(W), .INW(INW)) u_alu (
    .ops      (ops),
    .acc      (acc_q),
    .ext      (ext_q),
    .dr       (dr_in),
    .inp      (inp_in),
    .y        (alu_y),
    .ext_next (alu_e)
  );

  // next-state
  always_comb begin
    ld_en  = ops_any(ops) & ~acc_clr & ~acc_inc;
    acc_en = acc_clr | acc_inc | ld_en;
    acc_d  = acc_q;
    if (acc_clr)      acc_d = '0;
    else if (acc_inc) acc_d = acc_q + W'(1);
    else if (ld_en)   acc_d = alu_y;

    ext_en = e_clr | e_cmp | ld_en;
    ext_d  = ext_q;
    if (e_clr)      ext_d = 1'b0;
    else if (e_cmp) ext_d = ~ext_q;
    else if (ld_en) ext_d = alu_e;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (ext_en) ext_q <= ext_d;
    end
  end

  assign acc_neg  = acc_q[W-1];
  assign acc_zero = ~(|acc_q);
endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk #(
  parameter int W   = 16,
  parameter int INW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_and,
  input logic           op_add,
  input logic           op_lddr,
  input logic           op_inp,
  input logic           op_cma,
  input logic           op_shr,
  input logic           op_shl,
  input logic           acc_clr,
  input logic           acc_inc,
  input logic           e_clr,
  input logic           e_cmp,
  input logic [W-1:0]   dr_in,
  input logic [INW-1:0] inp_in,
  input logic [W-1:0]   acc_q,
  input logic           ext_q,
  input logic           acc_neg,
  input logic           acc_zero
);
  logic any_op;
  logic only_dp;
  logic no_e;
  assign any_op  = op_and | op_add | op_lddr | op_inp | op_cma | op_shr | op_shl;
  assign only_dp = !acc_clr && !acc_inc;
  assign no_e    = !e_clr && !e_cmp;

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_q == '0) && acc_zero && !acc_neg);
  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && acc_inc && no_e) |=> (acc_q == $past(acc_q) + W'(1)) && $stable(ext_q));
  // R4
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_dp && no_e && op_add) |=>
      ({ext_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(dr_in)})));
  // R5
  and_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_dp && no_e && op_and) |=> (acc_q == ($past(acc_q) & $past(dr_in))) && $stable(ext_q));
  // R6
  inp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_dp && op_inp) |=> (acc_q[INW-1:0] == $past(inp_in)) &&
                            (acc_q[W-1:INW] == $past(acc_q[W-1:INW])));
  // R7
  cma_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_dp && op_cma) |=> (acc_q == ~$past(acc_q)));
  // R8
  shr_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_dp && no_e && op_shr) |=>
      ({acc_q, ext_q} == {$past(ext_q), $past(acc_q)}));
  // R9
  shl_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_dp && no_e && op_shl) |=>
      ({ext_q, acc_q} == {$past(acc_q), $past(ext_q)}));
  // R10
  eclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_clr |=> !ext_q);
  // R10
  ecmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!e_clr && e_cmp) |=> (ext_q != $past(ext_q)));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_op && only_dp && no_e) |=> $stable(acc_q) && $stable(ext_q));
  // R12
  sign_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_neg == acc_q[W-1]);
endmodule

bind accum_core accum_core_chk #(.W(W), .INW(INW)) u_chk (.*);

// File: tb/accum_core_test.sv
`timescale 1ns/1ps
module accum_core_test;
  localparam int W = 16;
  localparam int INW = 8;
  localparam int B_AND = 0, B_ADD = 1, B_LDDR = 2, B_INP = 3, B_CMA = 4,
                 B_SHR = 5, B_SHL = 6, B_CLR = 7, B_INC = 8, B_ECLR = 9,
                 B_ECMP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] en = '0;
  logic [W-1:0] dr_in = '0;
  logic [INW-1:0] inp_in = '0;
  logic [W-1:0] acc_q;
  logic ext_q, acc_neg, acc_zero;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [W-1:0] m_ac;
  logic m_e;

  always #5 clk = ~clk;

  accum_core #(.W(W), .INW(INW)) uut (
    .clk(clk), .rst_n(rst_n),
    .op_and(en[B_AND]), .op_add(en[B_ADD]), .op_lddr(en[B_LDDR]),
    .op_inp(en[B_INP]), .op_cma(en[B_CMA]), .op_shr(en[B_SHR]),
    .op_shl(en[B_SHL]), .acc_clr(en[B_CLR]), .acc_inc(en[B_INC]),
    .e_clr(en[B_ECLR]), .e_cmp(en[B_ECMP]),
    .dr_in(dr_in), .inp_in(inp_in),
    .acc_q(acc_q), .ext_q(ext_q), .acc_neg(acc_neg), .acc_zero(acc_zero));

  task automatic model_step();
    logic [W:0] s;
    logic [W-1:0] a0;
    logic e0;
    logic ld;
    a0 = m_ac; e0 = m_e;
    ld = (|en[6:0]) && !en[B_CLR] && !en[B_INC];
    if (en[B_CLR]) m_ac = 0;
    else if (en[B_INC]) m_ac = a0 + 1;
    else if (ld) begin
      s = {1'b0, a0} + {1'b0, dr_in};
      if (en[B_AND]) m_ac = a0 & dr_in;
      else if (en[B_ADD]) m_ac = s[W-1:0];
      else if (en[B_LDDR]) m_ac = dr_in;
      else if (en[B_INP]) m_ac = {a0[W-1:INW], inp_in};
      else if (en[B_CMA]) m_ac = ~a0;
      else if (en[B_SHR]) m_ac = {e0, a0[W-1:1]};
      else m_ac = {a0[W-2:0], e0};
    end
    if (en[B_ECLR]) m_e = 0;
    else if (en[B_ECMP]) m_e = ~e0;
    else if (ld && en[B_ADD]) m_e = s[W];
    else if (ld && en[B_SHR]) m_e = a0[0];
    else if (ld && en[B_SHL]) m_e = a0[W-1];
  endtask

  task automatic compare(input string req);
    checks++;
    if (acc_q !== m_ac || ext_q !== m_e || acc_neg !== m_ac[W-1] ||
        acc_zero !== (m_ac == 0)) begin
      fails++;
      $display("FAIL %s: acc=%h e=%b neg=%b zero=%b expected acc=%h e=%b neg=%b zero=%b",
               req, acc_q, ext_q, acc_neg, acc_zero, m_ac, m_e, m_ac[W-1], m_ac == 0);
    end
  endtask

  task automatic apply(input logic [10:0] e, input logic [W-1:0] d,
                       input logic [INW-1:0] ib, input string req);
    en = e; dr_in = d; inp_in = ib;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
  endtask

  function automatic logic [10:0] bitv(input int b);
    return 11'(1) << b;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_ac = 0; m_e = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    apply('0, 16'h0, 8'h0, "R1 first edge");
    // R5 load and AND
    apply(bitv(B_LDDR), 16'hF0F3, 8'h0, "R5 load");
    apply(bitv(B_AND), 16'h3C3C, 8'h0, "R5 and");
    // R7 complement
    apply(bitv(B_CMA), 16'h0, 8'h0, "R7 cma");
    // R6 input keeps high byte
    apply(bitv(B_INP), 16'h0, 8'hA5, "R6 inp");
    // R4 full-length carry
    apply(bitv(B_LDDR), 16'hFFFF, 8'h0, "R5 load ffff");
    apply(bitv(B_ADD), 16'h0001, 8'h0, "R4 add carry");
    apply(bitv(B_ADD), 16'h7FFF, 8'h0, "R4 add no carry");
    // R8 / R9 rotates through E
    apply(bitv(B_ECMP), 16'h0, 8'h0, "R10 ecmp");
    apply(bitv(B_SHR), 16'h0, 8'h0, "R8 shr");
    apply(bitv(B_SHR), 16'h0, 8'h0, "R8 shr 2");
    apply(bitv(B_SHL), 16'h0, 8'h0, "R9 shl");
    apply(bitv(B_SHL), 16'h0, 8'h0, "R9 shl 2");
    // R3 wrap to zero
    apply(bitv(B_LDDR), 16'hFFFF, 8'h0, "R5 load ffff again");
    apply(bitv(B_INC), 16'h0, 8'h0, "R3 inc wrap R12 zero");
    apply(bitv(B_INC), 16'h0, 8'h0, "R3 inc");
    // R2 priority over inc and load; E untouched
    apply(bitv(B_CLR) | bitv(B_INC) | bitv(B_SHR), 16'h1234, 8'h0, "R2 clr priority");
    // R3 priority over add, E not written
    apply(bitv(B_INC) | bitv(B_ADD), 16'hFFFF, 8'h0, "R3 inc over add");
    // R10 E ops, AC kept
    apply(bitv(B_ECLR), 16'h0, 8'h0, "R10 eclr");
    apply(bitv(B_ECLR) | bitv(B_ECMP), 16'h0, 8'h0, "R10 eclr over ecmp");
    apply(bitv(B_ECMP) | bitv(B_SHL), 16'h0, 8'h0, "R10 ecmp over shl");
    // R11 hold with operands changing
    apply('0, 16'hBEEF, 8'h77, "R11 idle");
    apply(bitv(B_LDDR), 16'h8001, 8'h0, "R12 sign");
    // random single-op traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [10:0] e;
      k = $urandom_range(0, 11);
      e = (k == 11) ? 11'h0 : bitv(k);
      if ($urandom_range(0, 9) == 0) e = e | bitv($urandom_range(7, 10));
      apply(e, 16'($urandom), 8'($urandom), "R4-mix random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule